// File: doc/BRIEF.md
# Two-Group Steerable Interrupt Router

The router gathers 32 level-sensitive request lines, split into two groups of 16, and forwards them to five processor interrupt lines. Every line has a mask bit. A line counts as active only while its request is high and its mask bit is set. Each active line drives the one processor output chosen by its current route. That output is the OR of all active lines routed to it, held in a register.

Only some lines can be rerouted. Their routes sit in 3-bit fields packed into four 16-bit steering registers. All other lines are wired to output 0. Software reaches the masks, the raw request levels and the steering registers over a small 16-bit register bus.

For each output, a status port gives the lowest-numbered active line routed there, with group 1 searched before group 2. A per-output stale flag is raised when an output is still asserted but no line drives it any more.

Top module: `irq_router`

## Requirements
- R1: A line is active when its request input is 1 and its mask bit is 1. `cpu_irq[n]` becomes 1 on the clock edge after any active line with route n appears, and returns to 0 on the edge after the last such line is deasserted or masked.
- R2: Reset is synchronous and active high. After reset:
  - both masks read 0x0000 and `cpu_irq`, `first_src` and `stale` are 0;
  - steering register 0 reads 0x0040, so group-1 line 2 goes to output 1;
  - steering register 2 reads 0x0002, so group-2 line 0 goes to output 2;
  - steering registers 1 and 3 read 0x0000.
- R3: The bus uses byte addresses with one 16-bit register per even address:
  - 0x00 returns the group-1 request levels (read-only);
  - 0x02 is the group-1 mask;
  - 0x04 returns the group-2 request levels (read-only);
  - 0x06 is the group-2 mask;
  - 0x08, 0x0A, 0x0C and 0x0E are steering registers 0 to 3.

  Read data appears on `bus_rdata` on the edge after a cycle with `bus_re` high. Odd or unmapped addresses read 0. Writes to the request addresses have no effect.
- R4: A write to a mask address replaces the whole mask. Each mask bit gates only its own line, so clearing one bit silences that line alone.
- R5: A steering field is 3 bits wide and holds 0 to 4, naming the output. In a write, a field with a value above 4 keeps its old value, while the other fields of the same write still update. Bits outside the implemented fields read 0.
- R6: Group-1 steering fields:
  - lines 0, 1, 2, 3 and 8 use register 0 at bit offsets 0, 3, 6, 9 and 12;
  - lines 9, 11 and 12 use register 1 at offsets 0, 6 and 9.
- R7: Group-2 steering fields:
  - lines 0, 1, 3, 4 and 5 use register 2 at offsets 0, 3, 6, 9 and 12;
  - lines 6 to 10 use register 3 at offsets 0, 3, 6, 9 and 12.
- R8: Every line without a steering field always drives output 0, whatever is written to the steering registers.
- R9: `first_src[5n+4:5n]` is registered with `cpu_irq`. It holds `{group, line}` of the lowest-numbered active line routed to output n, where group is 0 for group 1 and 1 for group 2. Group 1 takes precedence over group 2. The field is 0 when no line is active.
- R10: `stale[n]` is 1 in a cycle where `cpu_irq[n]` is 1 but no active line is currently routed to output n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| req_g1 | input | 16 | Group-1 level requests |
| req_g2 | input | 16 | Group-2 level requests |
| cpu_irq | output | 5 | Processor interrupt lines |
| first_src | output | 25 | Lowest active line per output, 5 bits each |
| stale | output | 5 | Output asserted with no active line behind it |

## Verification
- **Register writes:** a write takes effect at the edge that samples it. Its effect on `cpu_irq` and `first_src` follows one edge later, so the bench samples one falling edge after the write task returns.
- **Request changes:** a request change shows on `cpu_irq` and `first_src` at the next rising edge. The bench drives requests on a falling edge and samples on the following falling edge.
- **Reads:** read data is checked on the falling edge after the sampling rising edge.
- **Stale flag:** `stale` is combinational against the registered outputs. It is checked 1 time unit after a request drops and again one cycle later, when `cpu_irq` has cleared.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int LINES  = 16;
  localparam int OUTS   = 5;
  localparam int FLDW   = 3;
  localparam int WORDW  = 16;
  localparam int NSTEER = 4;
  localparam int NSLOT  = 5;
  localparam int ADDRW  = 5;

  typedef struct packed {
    logic       ok;
    logic [1:0] sreg;
    logic [2:0] slot;
  } slot_t;

  // Which steering register and slot serves a line; ok=0 means fixed to output 0.
  function automatic slot_t slot_of(input bit grp, input int line);
    slot_t s;
    s = '0;
    if (!grp) begin
      if (line <= 3)        begin s.ok = 1'b1; s.sreg = 2'd0; s.slot = 3'(line); end
      else if (line == 8)   begin s.ok = 1'b1; s.sreg = 2'd0; s.slot = 3'd4; end
      else if (line == 9)   begin s.ok = 1'b1; s.sreg = 2'd1; s.slot = 3'd0; end
      else if (line == 11)  begin s.ok = 1'b1; s.sreg = 2'd1; s.slot = 3'd2; end
      else if (line == 12)  begin s.ok = 1'b1; s.sreg = 2'd1; s.slot = 3'd3; end
    end else begin
      if (line <= 1)        begin s.ok = 1'b1; s.sreg = 2'd2; s.slot = 3'(line); end
      else if (line >= 3 && line <= 5)
                            begin s.ok = 1'b1; s.sreg = 2'd2; s.slot = 3'(line - 1); end
      else if (line >= 6 && line <= 10)
                            begin s.ok = 1'b1; s.sreg = 2'd3; s.slot = 3'(line - 6); end
    end
    return s;
  endfunction

  // A slot is implemented when some line of either group maps onto it.
  function automatic bit slot_used(input int r, input int f);
    bit u;
    u = 1'b0;
    for (int g = 0; g < 2; g++)
      for (int l = 0; l < LINES; l++) begin
        slot_t s;
        s = slot_of(g[0], l);
        if (s.ok && int'(s.sreg) == r && int'(s.slot) == f) u = 1'b1;
      end
    return u;
  endfunction

  function automatic logic [WORDW-1:0] steer_reset(input int r);
    case (r)
      0:       return 16'h0040;
      2:       return 16'h0002;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_router_pkg::*;
#(
  parameter int DW = WORDW,
  parameter int NS = NSTEER,
  parameter int AW = ADDRW,
  parameter int NO = OUTS,
  parameter int FW = FLDW,
  parameter int NF = NSLOT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic                   re,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  input  logic [DW-1:0]          req1,
  input  logic [DW-1:0]          req2,
  output logic [DW-1:0]          rdata,
  output logic [DW-1:0]          mask1,
  output logic [DW-1:0]          mask2,
  output logic [NS-1:0][DW-1:0]  steer
);
  localparam int IW       = AW - 1;
  localparam int STEER_LO = 4;

  logic [IW-1:0] idx;
  logic          even;
  logic [DW-1:0] rd_mux;

  assign idx  = addr[AW-1:1];
  assign even = !addr[0];

  function automatic logic [DW-1:0] merge(input int r, input logic [DW-1:0] cur,
                                          input logic [DW-1:0] wd);
    logic [DW-1:0] res;
    res = cur;
    for (int f = 0; f < NF; f++)
      if (slot_used(r, f) && int'(wd[FW*f +: FW]) < NO)
        res[FW*f +: FW] = wd[FW*f +: FW];
    return res;
  endfunction

  always_comb begin
    rd_mux = '0;
    if (even) begin
      case (int'(idx))
        0: rd_mux = req1;
        1: rd_mux = mask1;
        2: rd_mux = req2;
        3: rd_mux = mask2;
        default: begin
          for (int r = 0; r < NS; r++)
            if (int'(idx) == STEER_LO + r) rd_mux = steer[r];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask1 <= '0;
      mask2 <= '0;
      rdata <= '0;
      for (int r = 0; r < NS; r++) steer[r] <= steer_reset(r);
    end else begin
      if (we && even && int'(idx) == 1) mask1 <= wdata;
      if (we && even && int'(idx) == 3) mask2 <= wdata;
      for (int r = 0; r < NS; r++)
        if (we && even && int'(idx) == STEER_LO + r) steer[r] <= merge(r, steer[r], wdata);
      if (re) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_steer.sv
module irq_steer
  import irq_router_pkg::*;
#(
  parameter bit GRP = 1'b0,
  parameter int NL  = LINES,
  parameter int NO  = OUTS,
  parameter int NS  = NSTEER,
  parameter int DW  = WORDW,
  parameter int FW  = FLDW
) (
  input  logic [NL-1:0]          req,
  input  logic [NL-1:0]          mask,
  input  logic [NS-1:0][DW-1:0]  steer,
  output logic [NO-1:0][NL-1:0]  hit
);
  wire unused_steer = ^steer;

  for (genvar p = 0; p < NL; p++) begin : g_line
    localparam slot_t S = slot_of(GRP, p);
    logic [FW-1:0] route;
    if (S.ok) begin : g_prog
      assign route = steer[S.sreg][FW*int'(S.slot) +: FW];
    end else begin : g_fixed
      assign route = '0;
    end
    for (genvar n = 0; n < NO; n++) begin : g_out
      assign hit[n][p] = req[p] && mask[p] && (route == FW'(n));
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_router_pkg::*;
#(
  parameter int NL = LINES,
  parameter int NO = OUTS,
  parameter int PW = $clog2(NL),
  parameter int IW = PW + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NO-1:0][NL-1:0] hit1,
  input  logic [NO-1:0][NL-1:0] hit2,
  output logic [NO-1:0]         irq,
  output logic [NO-1:0][IW-1:0] first,
  output logic [NO-1:0]         stale
);
  logic [NO-1:0]         any_now;
  logic [NO-1:0][IW-1:0] id_d;

  always_comb begin
    for (int n = 0; n < NO; n++) begin
      any_now[n] = (|hit1[n]) || (|hit2[n]);
      id_d[n]    = '0;
      for (int p = NL - 1; p >= 0; p--)
        if (hit2[n][p]) id_d[n] = {1'b1, PW'(p)};
      for (int p = NL - 1; p >= 0; p--)
        if (hit1[n][p]) id_d[n] = {1'b0, PW'(p)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq   <= '0;
      first <= '0;
    end else begin
      irq   <= any_now;
      first <= id_d;
    end
  end

  assign stale = irq & ~any_now;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NL = LINES,
  parameter int NO = OUTS,
  parameter int DW = WORDW,
  parameter int NS = NSTEER,
  parameter int AW = ADDRW,
  parameter int IW = $clog2(NL) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NL-1:0]    req_g1,
  input  logic [NL-1:0]    req_g2,
  output logic [NO-1:0]    cpu_irq,
  output logic [NO*IW-1:0] first_src,
  output logic [NO-1:0]    stale
);
  logic [DW-1:0]          mask1, mask2;
  logic [NS-1:0][DW-1:0]  steer;
  logic [NO-1:0][NL-1:0]  hit1, hit2;
  logic [NO-1:0][IW-1:0]  first_arr;

  irq_regs #(.DW(DW), .NS(NS), .AW(AW), .NO(NO)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .re(bus_re), .addr(bus_addr),
    .wdata(bus_wdata), .req1(req_g1), .req2(req_g2), .rdata(bus_rdata),
    .mask1(mask1), .mask2(mask2), .steer(steer)
  );

  irq_steer #(.GRP(1'b0), .NL(NL), .NO(NO), .NS(NS), .DW(DW)) u_steer1 (
    .req(req_g1), .mask(mask1), .steer(steer), .hit(hit1)
  );

  irq_steer #(.GRP(1'b1), .NL(NL), .NO(NO), .NS(NS), .DW(DW)) u_steer2 (
    .req(req_g2), .mask(mask2), .steer(steer), .hit(hit2)
  );

  irq_pick #(.NL(NL), .NO(NO)) u_pick (
    .clk(clk), .rst(rst), .hit1(hit1), .hit2(hit2),
    .irq(cpu_irq), .first(first_arr), .stale(stale)
  );

  assign first_src = first_arr;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NO = OUTS,
  parameter int DW = WORDW,
  parameter int NS = NSTEER,
  parameter int AW = ADDRW,
  parameter int IW = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_we,
  input logic [AW-1:0]         bus_addr,
  input logic [DW-1:0]         bus_wdata,
  input logic [DW-1:0]         mask1,
  input logic [DW-1:0]         mask2,
  input logic [NS-1:0][DW-1:0] steer,
  input logic [NO-1:0]         cpu_irq,
  input logic [NO*IW-1:0]      first_src
);
  // R2: outputs are quiet on the first cycle out of reset
  a_r2_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cpu_irq == '0);

  // R1: with both masks clear in the previous cycle no output can be high
  a_r1_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mask1) == '0 && $past(mask2) == '0) |-> cpu_irq == '0);

  // R4: a mask write replaces the whole group-1 mask
  a_r4_mask_write: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_we) && $past(bus_addr) == AW'(2)) |-> mask1 == $past(bus_wdata));

  // R5: every steering field always holds a legal output number
  for (genvar r = 0; r < NS; r++) begin : g_reg
    for (genvar f = 0; f < NSLOT; f++) begin : g_fld
      a_r5_field_legal: assert property (@(posedge clk) disable iff (rst)
        int'(steer[r][FLDW*f +: FLDW]) < NO);
    end
  end

  // R9: a nonzero status entry implies its output is asserted
  for (genvar n = 0; n < NO; n++) begin : g_out
    a_r9_status_has_irq: assert property (@(posedge clk) disable iff (rst)
      (first_src[IW*n +: IW] != '0) |-> cpu_irq[n]);
  end
endmodule

bind irq_router irq_router_chk u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .mask1(mask1), .mask2(mask2), .steer(steer),
  .cpu_irq(cpu_irq), .first_src(first_src)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
  localparam int CLK_P = 10;
  localparam int NVEC  = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] req_g1 = '0, req_g2 = '0;
  logic [4:0]  cpu_irq;
  logic [24:0] first_src;
  logic [4:0]  stale;

  int  n_chk = 0, n_fail = 0;
  bit  done  = 1'b0;

  irq_router u_irq_router (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_g1(req_g1), .req_g2(req_g2),
    .cpu_irq(cpu_irq), .first_src(first_src), .stale(stale)
  );

  always #(CLK_P/2) clk = ~clk;

  // {req_g1, req_g2, mask1, mask2, expected cpu_irq} with reset routing
  localparam logic [68:0] VEC [NVEC] = '{
    {16'h0004, 16'h0000, 16'hFFFF, 16'h0000, 5'b00010},
    {16'h0004, 16'h0000, 16'hFFFB, 16'h0000, 5'b00000},
    {16'h0000, 16'h0001, 16'h0000, 16'h0001, 5'b00100},
    {16'h8000, 16'h0002, 16'h8000, 16'h0002, 5'b00001},
    {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 5'b00111},
    {16'h0014, 16'h0000, 16'h0014, 16'h0000, 5'b00011},
    {16'h0014, 16'h0000, 16'h0010, 16'h0000, 5'b00001}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic drive(input logic [15:0] g1, input logic [15:0] g2);
    req_g1 = g1; req_g2 = g2;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state
    check("R2 irq", int'(cpu_irq), 0);
    check("R2 first_src", int'(first_src), 0);
    check("R2 stale", int'(stale), 0);
    rd(5'h02, d); check("R2 mask1", int'(d), 16'h0000);
    rd(5'h06, d); check("R2 mask2", int'(d), 16'h0000);
    rd(5'h08, d); check("R2 steer0", int'(d), 16'h0040);
    rd(5'h0A, d); check("R2 steer1", int'(d), 16'h0000);
    rd(5'h0C, d); check("R2 steer2", int'(d), 16'h0002);
    rd(5'h0E, d); check("R2 steer3", int'(d), 16'h0000);

    // R3 register map, read-only request levels, unmapped reads
    req_g1 = 16'h1234; req_g2 = 16'hA5A5;
    rd(5'h00, d); check("R3 req_g1 read", int'(d), 16'h1234);
    rd(5'h04, d); check("R3 req_g2 read", int'(d), 16'hA5A5);
    wr(5'h00, 16'hFFFF);
    rd(5'h00, d); check("R3 request write ignored", int'(d), 16'h1234);
    rd(5'h01, d); check("R3 odd address", int'(d), 0);
    rd(5'h10, d); check("R3 unmapped address", int'(d), 0);
    wr(5'h02, 16'hFFFF);
    rd(5'h02, d); check("R4 mask1 readback", int'(d), 16'hFFFF);

    // Vector table: R1, R4, R8
    for (int i = 0; i < NVEC; i++) begin
      wr(5'h02, VEC[i][36:21]);
      wr(5'h06, VEC[i][20:5]);
      drive(VEC[i][68:53], VEC[i][52:37]);
      check($sformatf("R1/R4 vector %0d", i), int'(cpu_irq), int'(VEC[i][4:0]));
    end

    // Group-1 steering: R5, R6, R8
    wr(5'h02, 16'hFFFF); wr(5'h06, 16'hFFFF);
    drive(16'h0000, 16'h0000);
    wr(5'h08, 16'h4000);
    rd(5'h08, d); check("R6 steer0 write", int'(d), 16'h4000);
    drive(16'h0100, 16'h0000); check("R6 g1 line8 to out4", int'(cpu_irq), 5'b10000);
    drive(16'h0004, 16'h0000); check("R6 g1 line2 to out0", int'(cpu_irq), 5'b00001);
    wr(5'h08, 16'h7008);
    rd(5'h08, d); check("R5 illegal field kept, legal field written", int'(d), 16'h4008);
    drive(16'h0002, 16'h0000); check("R6 g1 line1 to out1", int'(cpu_irq), 5'b00010);
    wr(5'h0A, 16'h0924);
    rd(5'h0A, d); check("R5 unused slots read 0", int'(d), 16'h0904);
    drive(16'h0800, 16'h0000); check("R6 g1 line11 to out4", int'(cpu_irq), 5'b10000);
    drive(16'h0400, 16'h0000); check("R8 g1 line10 fixed", int'(cpu_irq), 5'b00001);
    wr(5'h0A, 16'hFFFF);
    rd(5'h0A, d); check("R5 all-illegal write ignored", int'(d), 16'h0904);

    // Group-2 steering: R7, R8
    wr(5'h0E, 16'h3000);
    drive(16'h0000, 16'h0400); check("R7 g2 line10 to out3", int'(cpu_irq), 5'b01000);
    drive(16'h0000, 16'h0800); check("R8 g2 line11 fixed", int'(cpu_irq), 5'b00001);
    wr(5'h0C, 16'h0600);
    rd(5'h0C, d); check("R7 steer2 write", int'(d), 16'h0600);
    drive(16'h0000, 16'h0010); check("R7 g2 line4 to out3", int'(cpu_irq), 5'b01000);
    drive(16'h0000, 16'h0001); check("R7 g2 line0 to out0", int'(cpu_irq), 5'b00001);

    // Status: R9
    drive(16'h0030, 16'h0000); check("R9 lowest in group 1", int'(first_src[4:0]), 5'h04);
    drive(16'h0000, 16'h0004); check("R9 group 2 entry", int'(first_src[4:0]), 5'h12);
    drive(16'h8000, 16'h0004); check("R9 group 1 first", int'(first_src[4:0]), 5'h0F);
    wr(5'h02, 16'h7FFF);
    @(negedge clk); check("R9 masked line skipped", int'(first_src[4:0]), 5'h12);
    wr(5'h02, 16'hFFFF);

    // Stale flag and drop timing: R10, R1
    drive(16'h0010, 16'h0000); check("R1 out0 high", int'(cpu_irq), 5'b00001);
    req_g1 = 16'h0000;
    #1;
    check("R10 stale set", int'(stale), 5'b00001);
    check("R10 irq still held", int'(cpu_irq), 5'b00001);
    @(negedge clk);
    check("R1 drop after one edge", int'(cpu_irq), 0);
    check("R10 stale clear", int'(stale), 0);
    drive(16'h0010, 16'h0000);
    wr(5'h02, 16'hFFEF);
    @(negedge clk); check("R4 single mask bit silences line", int'(cpu_irq), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule